// File: doc/BRIEF.md
# Streaming Nucleotide Pattern Matcher

The block watches a stream of DNA bases arriving one 2-bit symbol per qualified cycle and reports each place where the most recent bases spell a fixed target word. The previous bases are held in a short history register. Together with the arriving base, they form a candidate window. Each window position is compared against its own constant base, and the per-position results are AND-reduced into one hit.

A hit is registered into a one-cycle match pulse. A saturating counter tallies the hits. The target word and its length are elaboration-time parameters. The default word is A, T, C, A, read in arrival order.

Each history slot has a fill bit that is cleared on reset. A window that is only partly filled can therefore never report a match. Occurrences that overlap are each reported.

Top module: `nuc_seq_matcher`

## Requirements
- R1: While reset is asserted, and after it has been released, `match_o` is 0 and `match_count_o` is 0 until the first match.
- R2: Bases are encoded A=2'b00, C=2'b01, G=2'b10, T=2'b11. With the default target, accepting the bases A, T, C, A in that order produces a match.
- R3: `match_o` rises on the clock edge that accepts the base completing a matching window. It stays high for exactly one cycle unless the next accepted base completes another match.
- R4: A cycle with `sym_valid_i` low neither shifts the window nor produces a match, whatever value `sym_i` carries. Bases separated by idle cycles match as if they were adjacent.
- R5: No match is reported until LEN bases have been accepted since reset, including when reset interrupts a partially matching sequence.
- R6: Overlapping occurrences are each reported. With the default target, the sequence A T C A T C A yields two matches.
- R7: `match_count_o` increments by one on each match and saturates at 2^CNT_W-1. After saturation, `match_o` still pulses.
- R8: A window that differs from the target in any single position produces no match and leaves the count unchanged.
- R9: The target is set by the PATTERN parameter. Bits [2k+1:2k] hold the base expected k positions before the newest one, so the least significant pair is the last base of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sym_valid_i | input | 1 | Qualifies `sym_i` for this cycle |
| sym_i | input | 2 | Incoming base code |
| match_o | output | 1 | Registered one-cycle pulse per matching window |
| match_count_o | output | CNT_W | Saturating count of matches |

## Verification
The assertions take for granted that `sym_valid_i` and `sym_i` are stable around the clock edge. They also assume no base is offered during the two cycles in which the internal reset is still being released, since the checker's fill counter runs from the external reset pin. The stimulus changes inputs only on the falling clock edge. After every reset it waits three cycles before offering a base. It returns the window to a known state by resetting it, rather than by shifting through it.

// File: rtl/nuc_pkg.sv
package nuc_pkg;
  localparam int unsigned BASE_W = 2;

  typedef enum logic [BASE_W-1:0] {
    BASE_A = 2'b00,
    BASE_C = 2'b01,
    BASE_G = 2'b10,
    BASE_T = 2'b11
  } base_e;
endpackage

// File: rtl/nuc_rst_sync.sv
module nuc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/nuc_history.sv
module nuc_history
  import nuc_pkg::*;
#(
  parameter int unsigned HIST = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift_en,
  input  logic [BASE_W-1:0]           base_i,
  output logic [HIST-1:0][BASE_W-1:0] hist_o,
  output logic [HIST-1:0]             fill_o
);
  logic [HIST-1:0][BASE_W-1:0] hist_q, hist_n;
  logic [HIST-1:0]             fill_q, fill_n;

  // Slot 0 is the newest stored base; each slot takes its younger neighbour.
  for (genvar k = 0; k < HIST; k++) begin : g_slot
    if (k == 0) begin : g_head
      assign hist_n[k] = shift_en ? base_i : hist_q[k];
      assign fill_n[k] = shift_en ? 1'b1   : fill_q[k];
    end else begin : g_tail
      assign hist_n[k] = shift_en ? hist_q[k-1] : hist_q[k];
      assign fill_n[k] = shift_en ? fill_q[k-1] : fill_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_n;
      fill_q <= fill_n;
    end
  end

  assign hist_o = hist_q;
  assign fill_o = fill_q;
endmodule

// File: rtl/nuc_compare.sv
module nuc_compare
  import nuc_pkg::*;
#(
  parameter int unsigned          LEN     = 4,
  parameter logic [2*LEN-1:0]     PATTERN = 8'h34
) (
  input  logic [LEN-1:0][BASE_W-1:0] win_i,
  input  logic [LEN-1:0]             win_fill_i,
  output logic                       hit_o
);
  logic [LEN-1:0] pos_eq;

  // One comparator per position, each tied to its own constant base.
  for (genvar k = 0; k < LEN; k++) begin : g_cmp
    localparam logic [BASE_W-1:0] WANT = PATTERN[BASE_W*k +: BASE_W];
    assign pos_eq[k] = win_fill_i[k] && (win_i[k] == WANT);
  end

  assign hit_o = &pos_eq;
endmodule

// File: rtl/nuc_tally.sv
module nuc_tally #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/nuc_seq_matcher.sv
module nuc_seq_matcher
  import nuc_pkg::*;
#(
  parameter int unsigned      LEN     = 4,
  parameter logic [2*LEN-1:0] PATTERN = 8'h34,
  parameter int unsigned      CNT_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sym_valid_i,
  input  logic [BASE_W-1:0]     sym_i,
  output logic                  match_o,
  output logic [CNT_W-1:0]      match_count_o
);
  localparam int unsigned HIST = LEN - 1;

  logic                        rst_core_n;
  logic [HIST-1:0][BASE_W-1:0] hist;
  logic [HIST-1:0]             hist_fill;
  logic [LEN-1:0][BASE_W-1:0]  cand;
  logic [LEN-1:0]              cand_fill;
  logic                        hit;
  logic                        match_q, match_n;

  nuc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  nuc_history #(.HIST(HIST)) u_hist (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .shift_en (sym_valid_i),
    .base_i   (sym_i),
    .hist_o   (hist),
    .fill_o   (hist_fill)
  );

  // Candidate window: stored history plus the base arriving this cycle.
  assign cand      = {hist, sym_i};
  assign cand_fill = {hist_fill, sym_valid_i};

  nuc_compare #(.LEN(LEN), .PATTERN(PATTERN)) u_cmp (
    .win_i      (cand),
    .win_fill_i (cand_fill),
    .hit_o      (hit)
  );

  nuc_tally #(.CNT_W(CNT_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .inc_i   (hit),
    .count_o (match_count_o)
  );

  always_comb begin
    match_n = hit;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      match_q <= 1'b0;
    end else begin
      match_q <= match_n;
    end
  end

  assign match_o = match_q;
endmodule

// File: rtl/nuc_seq_matcher_chk.sv
module nuc_seq_matcher_chk #(
  parameter int unsigned      LEN     = 4,
  parameter logic [2*LEN-1:0] PATTERN = 8'h34,
  parameter int unsigned      CNT_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sym_valid_i,
  input logic [1:0]       sym_i,
  input logic             match_o,
  input logic [CNT_W-1:0] match_count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int unsigned      FILL_W  = $clog2(LEN + 1);
  localparam logic [FILL_W-1:0] FILL_TOP = FILL_W'(LEN);

  logic [FILL_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (sym_valid_i && (seen_q != FILL_TOP)) begin
      seen_q <= seen_q + FILL_W'(1);
    end
  end

  // R5
  partial_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> (seen_q == FILL_TOP));

  // R4
  idle_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(sym_valid_i));

  // R9
  last_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> ($past(sym_i) == PATTERN[1:0]));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> ((match_count_o == CNT_W'($past(match_count_o) + CNT_W'(1))) ||
                 (($past(match_count_o) == CNT_MAX) && (match_count_o == CNT_MAX))));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !match_o |-> $stable(match_count_o));
endmodule

bind nuc_seq_matcher nuc_seq_matcher_chk #(
  .LEN(LEN), .PATTERN(PATTERN), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sym_valid_i   (sym_valid_i),
  .sym_i         (sym_i),
  .match_o       (match_o),
  .match_count_o (match_count_o)
);

// File: tb/nuc_seq_matcher_test.sv
module nuc_seq_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [1:0]  sym = 2'b00;
  logic        match;
  logic [15:0] cnt;
  logic        match_s;
  logic [3:0]  cnt_s;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [1:0] A = 2'b00, C = 2'b01, G = 2'b10, T = 2'b11;

  always #10 clk = ~clk;

  nuc_seq_matcher uut (
    .clk(clk), .rst_n(rst_n), .sym_valid_i(vld), .sym_i(sym),
    .match_o(match), .match_count_o(cnt)
  );

  nuc_seq_matcher #(.LEN(4), .PATTERN(8'h00), .CNT_W(4)) uut_sat (
    .clk(clk), .rst_n(rst_n), .sym_valid_i(vld), .sym_i(sym),
    .match_o(match_s), .match_count_o(cnt_s)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [1:0] b);
    vld = 1'b1; sym = b;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic idle(input int n, input logic [1:0] junk);
    sym = junk;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 match in reset", int'(match), 0);
    check("R1 count in reset", int'(cnt), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 match after reset", int'(match), 0);
    check("R1 count after reset", int'(cnt), 0);
  endtask

  task automatic t_basic();
    do_reset();
    push(A); check("R5 one base", int'(match), 0);
    push(T); check("R5 two bases", int'(match), 0);
    push(C); check("R5 three bases", int'(match), 0);
    push(A); check("R2 ATCA match", int'(match), 1);
    check("R7 count one", int'(cnt), 1);
    idle(1, A);
    check("R3 pulse one cycle", int'(match), 0);
    check("R3 count held", int'(cnt), 1);
  endtask

  task automatic t_gaps();
    do_reset();
    push(A); idle(3, A);
    check("R4 idle no shift", int'(match), 0);
    push(T); idle(2, C);
    push(C); idle(1, A);
    check("R4 idle junk no match", int'(match), 0);
    push(A);
    check("R4 gapped match", int'(match), 1);
    check("R4 gapped count", int'(cnt), 1);
  endtask

  task automatic t_reset_mid();
    do_reset();
    push(A); push(T); push(C);
    do_reset();
    push(A);
    check("R5 reset clears window", int'(match), 0);
    check("R5 count after mid reset", int'(cnt), 0);
  endtask

  task automatic t_overlap();
    do_reset();
    push(A); push(T); push(C); push(A);
    check("R6 first hit", int'(match), 1);
    push(T); check("R6 gap 1", int'(match), 0);
    push(C); check("R6 gap 2", int'(match), 0);
    push(A);
    check("R6 second hit", int'(match), 1);
    check("R6 count two", int'(cnt), 2);
  endtask

  task automatic t_mismatch();
    logic [1:0] word [4];
    word[0] = A; word[1] = T; word[2] = C; word[3] = A;
    for (int p = 0; p < 4; p++) begin
      do_reset();
      for (int i = 0; i < 4; i++) push((i == p) ? G : word[i]);
      check($sformatf("R8 position %0d differs", p), int'(match), 0);
      check($sformatf("R8 count position %0d", p), int'(cnt), 0);
    end
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 18; i++) push(A);
    check("R9 AAAA target count", int'(cnt_s), 15);
    check("R9 default ignores AAAA", int'(cnt), 0);
    push(A); push(A);
    check("R7 saturated count", int'(cnt_s), 15);
    check("R7 pulse after saturation", int'(match_s), 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_gaps();
    t_reset_mid();
    t_overlap();
    t_mismatch();
    t_saturate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule